// File: doc/BRIEF.md
# Serial ADC Conversion Host

This block is the host side of a link to a two-input, 12-bit successive-approximation converter that speaks a three-wire SPI protocol. One request runs one conversion. The request names an input (or the polarity of the input pair), says whether the inputs form a pseudo-differential pair, and carries the converter's output-order flag. The block lowers chip select, sends a byte-aligned command frame, and gathers the 12-bit code from the returned bits. It then presents the code with a one-cycle valid pulse.

The command is odd in length, so it is padded with seven leading zero bits and sent as three 8-bit groups, 24 serial clocks in all. The code then always falls in the low nibble of the second returned byte and the whole of the third. The serial clock comes from the system clock through a fixed divider. Both clock-idle polarities are built from one parameter. The block also enforces the chip-select setup and the minimum chip-select high time between conversions.

Top module: `adc_spi_host`

## Requirements
- R1: Each frame begins with seven zero bits on `spi_mosi` followed by a single 1 start bit, so the start bit is the 8th bit clocked.
- R2: The 9th, 10th and 11th bits are, in order: the single-ended flag (1 when `req_diff` is 0, 0 when `req_diff` is 1), `req_odd`, and `req_msbf`. All bits after the 11th are 0.
- R3: One accepted request produces exactly 24 rising serial clock edges, all with `spi_cs_n` low.
- R4: With `CPOL`=0 the serial clock idles low, and with `CPOL`=1 it idles high, whenever `spi_cs_n` is high. While chip select stays low, `spi_mosi` changes only together with a falling serial clock edge. `spi_miso` is taken on rising edges.
- R5: `res_data` holds the bits sampled on rising edges 13 through 24, first sampled bit in bit 11. The bits sampled on edges 9 to 11 are ignored. `req_msbf` does not change which bits are collected.
- R6: `res_valid` is a single-cycle pulse raised in the same cycle that `spi_cs_n` returns high. `res_data` and `res_err` are valid while it is high.
- R7: `res_err` is 1 when the bit sampled on rising edge 12 (the null bit) is 1, and 0 when it is 0.
- R8: Every serial clock high phase and every low phase inside a frame lasts `SCLK_HALF` system clocks. Elaboration stops on a divider whose phases are shorter than 250 ns, or whose clock is above `SCLK_MAX_HZ` or below `SCLK_MIN_HZ`.
- R9: Between frames, and after reset, `spi_cs_n` stays high for at least ceil(500 ns x system clock) cycles, which is 63 cycles at 125 MHz. `req_ready` stays low until that time has passed. A request already waiting is taken so that the high time is exactly that minimum.
- R10: After `spi_cs_n` falls, the serial clock holds its idle level for ceil(100 ns x system clock) cycles, which is 13 at 125 MHz, before its first edge.
- R11: A request raised while `req_ready` is low is ignored. It starts no frame, then or later.
- R12: During and right after reset, `spi_cs_n` is 1, the serial clock is at its idle level, `spi_mosi` is 0, and `res_valid` and `req_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Conversion request; taken in a cycle where req_ready is 1 |
| req_ready | output | 1 | Block idle and chip-select high time satisfied |
| req_diff | input | 1 | 1 selects the pseudo-differential pair |
| req_odd | input | 1 | Input select (single-ended) or pair polarity (differential) |
| req_msbf | input | 1 | Output-order flag placed in the command |
| spi_cs_n | output | 1 | Converter chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Command bits to the converter |
| spi_miso | input | 1 | Result bits from the converter |
| res_valid | output | 1 | One-cycle pulse with a new result |
| res_data | output | 12 | Conversion code |
| res_err | output | 1 | Null bit was not zero |

## Verification
The end of one frame and the start of the next can fall on adjacent edges. The valid pulse, the rise of chip select and the start of the high-time count share one edge. The first cycle of ready then meets a request that has been held since that pulse. The bench keeps each request asserted from the moment the previous result appears, measures chip-select high time at the pins, and requires exactly the minimum count along with exactly one new frame per request. A second directed case raises a request in the middle of a frame. It then confirms at the pins that no further frame begins once the gap has expired.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;

  localparam int FRAME_BITS = 24;
  localparam int CODE_BITS  = 12;
  // samples kept: the null bit plus the code bits
  localparam int KEEP_BITS  = CODE_BITS + 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_GAP
  } host_state_t;

  typedef struct packed {
    logic diff;
    logic odd;
    logic msbf;
  } conv_cmd_t;

  // seven pad zeros, start bit, three command bits, then zeros
  function automatic logic [FRAME_BITS-1:0] build_frame(conv_cmd_t c);
    logic [FRAME_BITS-1:0] f;
    f = '0;
    f[FRAME_BITS-8]  = 1'b1;
    f[FRAME_BITS-9]  = ~c.diff;
    f[FRAME_BITS-10] = c.odd;
    f[FRAME_BITS-11] = c.msbf;
    return f;
  endfunction

endpackage

// File: rtl/adc_spi_divider.sv
module adc_spi_divider #(
  parameter int HALF = 35
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt;
  logic          hi_phase;
  logic          expire;

  assign expire   = run && (cnt == CW'(HALF - 1));
  assign rise_stb = expire && !hi_phase;
  assign fall_stb = expire && hi_phase;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt      <= '0;
      hi_phase <= 1'b0;
    end else if (expire) begin
      cnt      <= '0;
      hi_phase <= ~hi_phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4: edges strictly alternate, a rise always before the next fall
  a_r4_alternate: assert property (@(posedge clk) disable iff (rst)
    rise_stb |=> !rise_stb);

endmodule

// File: rtl/adc_spi_shifter.sv
module adc_spi_shifter
  import adc_spi_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  rise_stb,
  input  logic                  fall_stb,
  input  logic                  miso,
  output logic                  mosi,
  output logic [KEEP_BITS-1:0]  rx,
  output logic                  last
);
  localparam int BW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] tx;
  logic [BW-1:0]         bitc;

  assign mosi = tx[FRAME_BITS-1];
  assign last = (bitc == BW'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx   <= '0;
      bitc <= '0;
      rx   <= '0;
    end else begin
      if (load) begin
        tx   <= frame;
        bitc <= '0;
      end else if (fall_stb) begin
        if (last) begin
          tx <= '0;
        end else begin
          tx   <= {tx[FRAME_BITS-2:0], 1'b0};
          bitc <= bitc + 1'b1;
        end
      end
      if (rise_stb) begin
        rx <= {rx[KEEP_BITS-2:0], miso};
      end
    end
  end

  // R3: a load never lands in the middle of a shifting frame
  a_r3_no_reload: assert property (@(posedge clk) disable iff (rst)
    load |-> !(rise_stb || fall_stb));

endmodule

// File: rtl/adc_spi_host.sv
module adc_spi_host
  import adc_spi_pkg::*;
#(
  parameter int CLK_HZ       = 125_000_000,
  parameter int SCLK_HALF    = 35,
  parameter bit CPOL         = 1'b0,
  parameter int SCLK_MAX_HZ  = 1_800_000,
  parameter int SCLK_MIN_HZ  = 10_000,
  parameter int MIN_PHASE_NS = 250,
  parameter int CS_GAP_NS    = 500,
  parameter int CS_SETUP_NS  = 100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_diff,
  input  logic                 req_odd,
  input  logic                 req_msbf,
  output logic                 spi_cs_n,
  output logic                 spi_sclk,
  output logic                 spi_mosi,
  input  logic                 spi_miso,
  output logic                 res_valid,
  output logic [CODE_BITS-1:0] res_data,
  output logic                 res_err
);
  localparam int CLK_MHZ   = CLK_HZ / 1_000_000;
  localparam int GAP_CYC   = (CS_GAP_NS * CLK_MHZ + 999) / 1000;
  localparam int SETUP_CYC = (CS_SETUP_NS * CLK_MHZ + 999) / 1000;
  localparam int SCLK_HZ   = CLK_HZ / (2 * SCLK_HALF);
  localparam int PHASE_NS  = (SCLK_HALF * 1000) / CLK_MHZ;
  localparam int GW        = $clog2(GAP_CYC + 1);
  localparam int SW        = $clog2(SETUP_CYC + 1);
  localparam int AGE_MAX   = ((GAP_CYC > SETUP_CYC) ? GAP_CYC : SETUP_CYC)
                             + SCLK_HALF + 2;
  localparam int AW        = $clog2(AGE_MAX + 1);

  // R8: divider settings outside the serial clock limits stop elaboration
  if (PHASE_NS < MIN_PHASE_NS) begin : g_bad_phase
    $error("serial clock phase shorter than the minimum high/low time");
  end
  if (SCLK_HZ > SCLK_MAX_HZ) begin : g_bad_fast
    $error("serial clock above the maximum rate");
  end
  if (SCLK_HZ < SCLK_MIN_HZ) begin : g_bad_slow
    $error("serial clock below the minimum rate");
  end
  if (GAP_CYC < 2 || SETUP_CYC < 1) begin : g_bad_timing
    $error("chip-select timing needs more system clock cycles");
  end

  host_state_t           state;
  logic [GW-1:0]         gcnt;
  logic [SW-1:0]         scnt;
  logic                  rise_stb, fall_stb, last;
  logic                  accept;
  logic [KEEP_BITS-1:0]  rx;
  logic [FRAME_BITS-1:0] frame;
  conv_cmd_t             cmd;

  assign cmd    = '{diff: req_diff, odd: req_odd, msbf: req_msbf};
  assign frame  = build_frame(cmd);
  assign accept = (state == ST_IDLE) && req_valid;

  adc_spi_divider #(.HALF(SCLK_HALF)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (state == ST_XFER),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  adc_spi_shifter u_shf (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .frame    (frame),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .miso     (spi_miso),
    .mosi     (spi_mosi),
    .rx       (rx),
    .last     (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_GAP;
      gcnt      <= '0;
      scnt      <= '0;
      spi_cs_n  <= 1'b1;
      spi_sclk  <= CPOL;
      req_ready <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      unique case (state)
        ST_GAP: begin
          // ready rises one cycle early so a waiting request lands on the limit
          if (gcnt == GW'(GAP_CYC - 2)) begin
            state     <= ST_IDLE;
            req_ready <= 1'b1;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (req_valid) begin
            req_ready <= 1'b0;
            spi_cs_n  <= 1'b0;
            scnt      <= '0;
            state     <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (scnt == SW'(SETUP_CYC - 1)) begin
            spi_sclk <= 1'b0;
            state    <= ST_XFER;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (rise_stb) begin
            spi_sclk <= 1'b1;
          end else if (fall_stb) begin
            if (last) begin
              spi_sclk  <= CPOL;
              spi_cs_n  <= 1'b1;
              res_valid <= 1'b1;
              res_data  <= rx[CODE_BITS-1:0];
              res_err   <= rx[CODE_BITS];
              gcnt      <= '0;
              state     <= ST_GAP;
            end else begin
              spi_sclk <= 1'b0;
            end
          end
        end
        default: state <= ST_GAP;
      endcase
    end
  end

  // ---------------- checks on the pins ----------------
  logic [AW-1:0] hi_age, lo_age, tog_age;
  logic          sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_age  <= '0;
      lo_age  <= '0;
      tog_age <= '0;
      sclk_d  <= CPOL;
    end else begin
      sclk_d <= spi_sclk;
      if (spi_cs_n) begin
        lo_age <= '0;
        if (hi_age != '1) hi_age <= hi_age + 1'b1;
      end else begin
        hi_age <= '0;
        if (lo_age != '1) lo_age <= lo_age + 1'b1;
      end
      if (spi_sclk != sclk_d)  tog_age <= '0;
      else if (tog_age != '1)  tog_age <= tog_age + 1'b1;
    end
  end

  a_r9_cs_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> hi_age >= AW'(GAP_CYC));

  a_r10_cs_setup: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && !$stable(spi_sclk) && $past(!spi_cs_n)) |-> lo_age >= AW'(SETUP_CYC));

  a_r8_phase_len: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && $past(!spi_cs_n) && !$stable(spi_sclk) && $past(lo_age) > AW'(SETUP_CYC))
      |-> tog_age >= AW'(SCLK_HALF - 1));

  a_r4_idle_level: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> (spi_sclk == CPOL));

  a_r4_mosi_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && $past(!spi_cs_n) && !$stable(spi_mosi)) |-> $fell(spi_sclk));

  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  a_r6_valid_with_cs: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $rose(spi_cs_n));

  a_r11_ready_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> spi_cs_n);

endmodule

// File: tb/sim_adc_spi_host.sv
module adc_dev_model (
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        mosi,
  input  logic [11:0] ch0,
  input  logic [11:0] ch1,
  input  logic        bad_null,
  output logic        miso,
  output int          done_rises,
  output int          done_spos,
  output logic        done_sgl,
  output logic        done_odd,
  output logic        done_msbf,
  output logic        done_tail,
  output int          frames
);
  int   rises = 0;
  int   spos = 0;
  logic started = 1'b0;
  logic sgl = 1'b0, odd = 1'b0, msbf = 1'b0, tail = 1'b0;
  logic [11:0] val;

  initial begin
    miso = 1'b1; frames = 0; done_rises = 0; done_spos = 0;
    done_sgl = 0; done_odd = 0; done_msbf = 0; done_tail = 0;
  end

  always_comb begin
    if (sgl) val = odd ? ch1 : ch0;
    else if (odd) val = (ch1 > ch0) ? ch1 - ch0 : 12'd0;
    else val = (ch0 > ch1) ? ch0 - ch1 : 12'd0;
  end

  always @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      if (rises != 0) begin
        done_rises <= rises; done_spos <= spos; done_sgl <= sgl;
        done_odd <= odd; done_msbf <= msbf; done_tail <= tail;
        frames <= frames + 1;
      end
      rises <= 0; started <= 1'b0; tail <= 1'b0;
    end else begin
      rises <= rises + 1;
      if (!started) begin
        if (mosi) begin started <= 1'b1; spos <= rises + 1; end
      end else if (rises + 1 == spos + 1) sgl <= mosi;
      else if (rises + 1 == spos + 2) odd <= mosi;
      else if (rises + 1 == spos + 3) msbf <= mosi;
      else if (mosi) tail <= 1'b1;
    end
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      if (started && rises == spos + 3) miso <= bad_null;
      else if (started && rises >= spos + 4 && rises <= spos + 15) miso <= val[15 + spos - rises];
      else miso <= 1'b1;
    end
  end
endmodule

module sim_adc_spi_host;
  localparam int HALF  = 35;
  localparam int GAP   = (500 * 125 + 999) / 1000;
  localparam int SETUP = (100 * 125 + 999) / 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rq_valid = 1'b0, rq_diff = 1'b0, rq_odd = 1'b0, rq_msbf = 1'b0;
  logic [11:0] ch0_v = '0, ch1_v = '0;
  logic bad_v = 1'b0;

  logic u0_ready, u0_cs_n, u0_sclk, u0_mosi, u0_miso, u0_valid, u0_err;
  logic u1_ready, u1_cs_n, u1_sclk, u1_mosi, u1_miso, u1_valid, u1_err;
  logic [11:0] u0_data, u1_data;

  int m0_rises, m0_spos, m0_frames, m1_rises, m1_spos, m1_frames;
  logic m0_sgl, m0_odd, m0_msbf, m0_tail, m1_sgl, m1_odd, m1_msbf, m1_tail;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  adc_spi_host #(.SCLK_HALF(HALF), .CPOL(1'b0)) u0 (
    .clk(clk), .rst(rst), .req_valid(rq_valid), .req_ready(u0_ready),
    .req_diff(rq_diff), .req_odd(rq_odd), .req_msbf(rq_msbf),
    .spi_cs_n(u0_cs_n), .spi_sclk(u0_sclk), .spi_mosi(u0_mosi), .spi_miso(u0_miso),
    .res_valid(u0_valid), .res_data(u0_data), .res_err(u0_err));

  adc_spi_host #(.SCLK_HALF(HALF), .CPOL(1'b1)) u1 (
    .clk(clk), .rst(rst), .req_valid(rq_valid), .req_ready(u1_ready),
    .req_diff(rq_diff), .req_odd(rq_odd), .req_msbf(rq_msbf),
    .spi_cs_n(u1_cs_n), .spi_sclk(u1_sclk), .spi_mosi(u1_mosi), .spi_miso(u1_miso),
    .res_valid(u1_valid), .res_data(u1_data), .res_err(u1_err));

  adc_dev_model m0 (.cs_n(u0_cs_n), .sclk(u0_sclk), .mosi(u0_mosi), .ch0(ch0_v), .ch1(ch1_v),
    .bad_null(bad_v), .miso(u0_miso), .done_rises(m0_rises), .done_spos(m0_spos),
    .done_sgl(m0_sgl), .done_odd(m0_odd), .done_msbf(m0_msbf), .done_tail(m0_tail),
    .frames(m0_frames));

  adc_dev_model m1 (.cs_n(u1_cs_n), .sclk(u1_sclk), .mosi(u1_mosi), .ch0(ch0_v), .ch1(ch1_v),
    .bad_null(bad_v), .miso(u1_miso), .done_rises(m1_rises), .done_spos(m1_spos),
    .done_sgl(m1_sgl), .done_odd(m1_odd), .done_msbf(m1_msbf), .done_tail(m1_tail),
    .frames(m1_frames));

  // pin timing monitors, sampled on pre-edge values
  int hi_run = 0, last_gap = 0, hw_run = 0, hw_min = 1000000, hw_max = 0, pre_rise = 0;
  int u1_pre = 0, u1_hi_run = 0;
  bit seen_rise = 0, u1_seen_fall = 0;

  always @(posedge clk) begin
    if (!rst) begin
      if (u0_cs_n) begin
        hi_run++; hw_run = 0;
      end else begin
        if (hi_run != 0) begin last_gap = hi_run; hi_run = 0; pre_rise = 0; seen_rise = 0; end
        if (u0_sclk) hw_run++;
        else if (hw_run != 0) begin
          if (hw_run < hw_min) hw_min = hw_run;
          if (hw_run > hw_max) hw_max = hw_run;
          hw_run = 0;
        end
        if (!seen_rise) begin
          if (u0_sclk) seen_rise = 1; else pre_rise++;
        end
      end
      if (u1_cs_n) u1_hi_run++;
      else begin
        if (u1_hi_run != 0) begin u1_hi_run = 0; u1_pre = 0; u1_seen_fall = 0; end
        if (!u1_seen_fall) begin
          if (!u1_sclk) u1_seen_fall = 1; else u1_pre++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] expect_code(bit d, bit o, logic [11:0] a, logic [11:0] b);
    if (!d) return o ? b : a;
    if (o) return (b > a) ? b - a : 12'd0;
    return (a > b) ? a - b : 12'd0;
  endfunction

  task automatic do_conv(input bit d, input bit o, input bit m, input logic [11:0] a,
                         input logic [11:0] b, input bit bad, input bit gap_chk,
                         input bit busy_poke);
    int fr0;
    logic [11:0] e;
    fr0 = m0_frames;
    ch0_v = a; ch1_v = b; bad_v = bad;
    rq_diff = d; rq_odd = o; rq_msbf = m; rq_valid = 1'b1;
    @(negedge clk);
    while (u0_cs_n) @(negedge clk);
    rq_valid = 1'b0;
    if (busy_poke) begin
      repeat (200) @(negedge clk);
      rq_diff = ~d; rq_odd = ~o; rq_msbf = ~m; rq_valid = 1'b1;
      repeat (300) @(negedge clk);
      rq_valid = 1'b0;
    end
    while (!u0_valid) @(negedge clk);
    e = expect_code(d, o, a, b);
    chk(u0_data == e, "R5 mode0 code", u0_data, e);
    chk(u1_data == e, "R5 mode3 code", u1_data, e);
    chk(u1_valid == 1'b1, "R6 mode3 valid", u1_valid, 1);
    chk(u0_cs_n == 1'b1, "R6 cs high with valid", u0_cs_n, 1);
    chk(u0_err == bad && u1_err == bad, "R7 null error", u0_err, bad);
    chk(m0_spos == 8 && m1_spos == 8, "R1 start position", m0_spos, 8);
    chk(m0_sgl == ~d && m1_sgl == ~d, "R2 single flag", m0_sgl, ~d);
    chk(m0_odd == o && m1_odd == o, "R2 odd bit", m0_odd, o);
    chk(m0_msbf == m && m1_msbf == m, "R2 order bit", m0_msbf, m);
    chk(!m0_tail && !m1_tail, "R2 trailing zeros", m0_tail, 0);
    chk(m0_rises == 24 && m1_rises == 24, "R3 clock count", m0_rises, 24);
    chk(m0_frames == fr0 + 1, "R11 one frame per request", m0_frames, fr0 + 1);
    if (gap_chk) chk(last_gap == GAP, "R9 exact cs high time", last_gap, GAP);
    else chk(last_gap >= GAP, "R9 min cs high time", last_gap, GAP);
    chk(u1_pre == SETUP, "R10 mode3 setup", u1_pre, SETUP);
    chk(pre_rise >= SETUP, "R10 mode0 setup", pre_rise, SETUP);
    if (busy_poke) begin
      repeat (150) @(negedge clk);
      chk(u0_cs_n == 1'b1, "R11 no frame from busy request", u0_cs_n, 1);
      chk(m0_frames == fr0 + 1, "R11 frame count", m0_frames, fr0 + 1);
      chk(u0_ready == 1'b1, "R9 ready after gap", u0_ready, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(u0_cs_n == 1'b1 && u1_cs_n == 1'b1, "R12 cs high", u0_cs_n, 1);
    chk(u0_sclk == 1'b0, "R12 mode0 idle low", u0_sclk, 0);
    chk(u1_sclk == 1'b1, "R12 mode3 idle high", u1_sclk, 1);
    chk(u0_mosi == 1'b0 && u0_valid == 1'b0, "R12 mosi and valid", u0_mosi, 0);
    chk(u0_ready == 1'b0, "R12 ready low", u0_ready, 0);
    repeat (10) @(negedge clk);
    chk(u0_ready == 1'b0, "R9 ready held after reset", u0_ready, 0);
    n = 0;
    while (!u0_ready && n < 100) begin @(negedge clk); n++; end
    chk(u0_ready == 1'b1, "R9 ready after reset gap", u0_ready, 1);

    // directed corners
    do_conv(1'b0, 1'b0, 1'b1, 12'hFFF, 12'h000, 1'b0, 1'b0, 1'b0);
    do_conv(1'b0, 1'b1, 1'b1, 12'hFFF, 12'h000, 1'b0, 1'b1, 1'b0);
    do_conv(1'b1, 1'b0, 1'b0, 12'h5A5, 12'h5A5, 1'b0, 1'b1, 1'b0);
    do_conv(1'b1, 1'b1, 1'b1, 12'h123, 12'hABC, 1'b0, 1'b1, 1'b0);
    do_conv(1'b0, 1'b0, 1'b0, 12'h800, 12'h001, 1'b1, 1'b1, 1'b0);
    do_conv(1'b1, 1'b0, 1'b1, 12'hA5A, 12'h05A, 1'b0, 1'b1, 1'b1);
    do_conv(1'b0, 1'b1, 1'b1, 12'h000, 12'h001, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < 28; i++) begin
      logic [11:0] a, b;
      a = 12'($urandom);
      b = 12'($urandom);
      if (($urandom % 8) == 0) a = 12'hFFF;
      if (($urandom % 8) == 0) b = a;
      do_conv(1'($urandom), 1'($urandom), 1'($urandom), a, b,
              (($urandom % 6) == 0), 1'b1, 1'b0);
    end

    chk(hw_min == HALF && hw_max == HALF, "R8 high phase length", hw_min, HALF);
    repeat (20) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule